// File: doc/BRIEF.md
# Slow-Attack AGC Peak Overload Arbiter

This block makes the gain decisions for a slow-attack automatic gain control loop in a receive path. Five detectors feed it single-cycle pulses: a large overload at the limiter stage, a large overload at the ADC, small peak overloads at either stage, and digital saturation. It also takes two average-power flags that come from the window loop: power above the high threshold and power below the low threshold. The block counts the pulses from each large detector and from digital saturation. It also runs a free-running gain update timer. From these it decides when the single gain index that drives every stage of the receive chain may move, in which direction, and by how many steps.

A large overload counts only after it has occurred more times than its programmed limit. Even a counted overload normally waits for the update timer to expire. A per-detector immediate enable lets a counted limiter or ADC overload act on the next clock instead. When several conditions are pending at once, a fixed priority picks one: limiter, then ADC, then digital saturation, then the power window. A small peak overload can block the window loop from raising the gain. Every gain change is reported for one cycle as a strobe with the signed index difference. The index itself is kept within the range of the gain table.

Top module: `agc_peak_arbiter`

## Requirements
- R1: After reset `gain_idx` equals INIT_IDX, `chg_valid` is 0 and `chg_delta` is 0. The timer, all occurrence counters and the small-peak flag start at zero.
- R2: The limiter, ADC and saturation counters each count pulses and saturate at 2^CNT_W-1. A source counts as qualified only while its count is strictly greater than its limit input.
- R3: The update timer counts from 0 and expires in the cycle its value equals `upd_period`, so it expires every `upd_period`+1 cycles. Without an immediate enable, a gain change happens only in an expiry cycle.
- R4: With `lim_immed_en` (or `adc_immed_en`) high, a qualified limiter (or ADC) overload fires a decision in the first cycle it is qualified, whatever the timer value.
- R5: When a decision is taken, the priority is: qualified limiter, then qualified ADC, then qualified saturation, then `pwr_high`, then `pwr_low`. Saturation and the power flags are considered only in an expiry cycle.
- R6: The requested delta is −`lim_dec_step` for the limiter, −`adc_dec_step` for the ADC, −(`dig_step`+1) for saturation, −`win_dec_step` for `pwr_high` and +`win_inc_step` for `pwr_low`.
- R7: While `inhibit_inc` is high and a small peak pulse (`lim_small_pls` or `adc_small_pls`) has been seen since the last clear, `pwr_low` produces no increase.
- R8: All counters and the small-peak flag clear after any decision cycle and after any expiry cycle. A pulse that arrives in such a cycle is discarded.
- R9: `gain_idx` never leaves 0..MAX_IDX. A request beyond either end is clamped, and `chg_delta` reports the difference actually applied.
- R10: A decision taken at one clock edge shows at that same edge as `chg_valid`=1 for one cycle, with `gain_idx` updated by `chg_delta`. When `chg_valid` is 0, `gain_idx` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_big_pls | input | 1 | Large limiter overload pulse |
| adc_big_pls | input | 1 | Large ADC overload pulse |
| lim_small_pls | input | 1 | Small limiter peak pulse |
| adc_small_pls | input | 1 | Small ADC peak pulse |
| dsat_pls | input | 1 | Digital saturation pulse |
| pwr_low | input | 1 | Average power below the low threshold |
| pwr_high | input | 1 | Average power above the high threshold |
| upd_period | input | TMR_W | Timer terminal value (period minus one) |
| lim_limit | input | CNT_W | Limiter occurrence limit |
| adc_limit | input | CNT_W | ADC occurrence limit |
| dsat_limit | input | CNT_W | Saturation occurrence limit |
| lim_immed_en | input | 1 | Counted limiter overload acts immediately |
| adc_immed_en | input | 1 | Counted ADC overload acts immediately |
| inhibit_inc | input | 1 | Block increases after a small peak |
| lim_dec_step | input | STEP_W | Limiter decrement step |
| adc_dec_step | input | STEP_W | ADC decrement step |
| dig_step | input | STEP_W | Digital gain step (saturation uses this plus one) |
| win_inc_step | input | STEP_W | Window loop increment step |
| win_dec_step | input | STEP_W | Window loop decrement step |
| gain_idx | output | IDX_W | Current gain index |
| chg_valid | output | 1 | One-cycle gain change strobe |
| chg_delta | output | IDX_W+1 | Signed applied index difference |

## Verification
The assertions check several properties on every cycle. The index always stays inside the table. It moves only together with the strobe, and then by exactly the reported delta. A decision outside an expiry cycle always comes from an enabled, qualified large overload. The counters are empty after each clear. A qualified limiter overload always wins, and no increase is chosen while blocked. Other behaviour can only be shown by the bench's scenarios, which compare the design against an arithmetic model: the strict "more than the limit" qualification, the exact timer period, the step sizes for each source, the clamped delta at both ends of the table, and the dropping of pulses that arrive in a clear cycle.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_LIM  = 3'd1,
    SRC_ADC  = 3'd2,
    SRC_DSAT = 3'd3,
    SRC_WDEC = 3'd4,
    SRC_WINC = 3'd5
  } agc_src_e;

  // saturation moves one more than the digital step
  function automatic int dsat_mag(input int step);
    return step + 1;
  endfunction

  // keep an index inside 0..hi
  function automatic int clamp_idx(input int v, input int hi);
    if (v < 0)  return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/agc_occ_counter.sv
`timescale 1ns/1ps
module agc_occ_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pulse,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             qual
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (pulse && (cnt != CNT_TOP)) cnt <= cnt + 1'b1;
  end

  assign qual = (cnt > limit);
endmodule

// File: rtl/agc_update_timer.sv
`timescale 1ns/1ps
module agc_update_timer #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] period,
  output logic             expire
);
  logic [TMR_W-1:0] tmr;

  assign expire = (tmr == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr <= '0;
    else if (expire) tmr <= '0;
    else             tmr <= tmr + 1'b1;
  end
endmodule

// File: rtl/agc_decide.sv
`timescale 1ns/1ps
module agc_decide import agc_pkg::*; #(
  parameter int STEP_W = 4,
  parameter int DW     = 8
) (
  input  logic                 expire,
  input  logic                 lim_q,
  input  logic                 adc_q,
  input  logic                 dsat_q,
  input  logic                 lim_imm_en,
  input  logic                 adc_imm_en,
  input  logic                 pwr_low,
  input  logic                 pwr_high,
  input  logic                 inhibit_inc,
  input  logic                 small_trip,
  input  logic [STEP_W-1:0]    lim_step,
  input  logic [STEP_W-1:0]    adc_step,
  input  logic [STEP_W-1:0]    dig_step,
  input  logic [STEP_W-1:0]    inc_step,
  input  logic [STEP_W-1:0]    dec_step,
  output logic                 fire,
  output agc_src_e             src,
  output logic signed [DW-1:0] req_delta
);
  logic act_now;
  logic inc_ok;
  int   mag;

  assign act_now = expire | (lim_imm_en & lim_q) | (adc_imm_en & adc_q);
  assign inc_ok  = !(inhibit_inc && small_trip);

  // without lim_q/adc_q, act_now can only come from the timer
  always_comb begin
    src = SRC_NONE;
    mag = 0;
    if (act_now) begin
      if (lim_q) begin
        src = SRC_LIM;  mag = -int'(lim_step);
      end else if (adc_q) begin
        src = SRC_ADC;  mag = -int'(adc_step);
      end else if (dsat_q) begin
        src = SRC_DSAT; mag = -dsat_mag(int'(dig_step));
      end else if (pwr_high) begin
        src = SRC_WDEC; mag = -int'(dec_step);
      end else if (pwr_low && inc_ok) begin
        src = SRC_WINC; mag = int'(inc_step);
      end
    end
  end

  assign fire      = (src != SRC_NONE);
  assign req_delta = DW'(mag);
endmodule

// File: rtl/agc_index_reg.sv
`timescale 1ns/1ps
module agc_index_reg import agc_pkg::*; #(
  parameter int IDX_W    = 7,
  parameter int DW       = 8,
  parameter int MAX_IDX  = 76,
  parameter int INIT_IDX = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic signed [DW-1:0] req_delta,
  output logic [IDX_W-1:0]     gain_idx,
  output logic                 chg_valid,
  output logic signed [DW-1:0] chg_delta
);
  int sum_i;
  int nxt_i;

  always_comb begin
    sum_i = int'(gain_idx) + int'(req_delta);
    nxt_i = clamp_idx(sum_i, MAX_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_idx  <= IDX_W'(INIT_IDX);
      chg_valid <= 1'b0;
      chg_delta <= '0;
    end else begin
      chg_valid <= fire;
      if (fire) begin
        gain_idx  <= IDX_W'(nxt_i);
        chg_delta <= DW'(nxt_i - int'(gain_idx));
      end
    end
  end
endmodule

// File: rtl/agc_peak_arbiter.sv
`timescale 1ns/1ps
module agc_peak_arbiter import agc_pkg::*; #(
  parameter int IDX_W    = 7,
  parameter int MAX_IDX  = 76,
  parameter int INIT_IDX = 40,
  parameter int CNT_W    = 3,
  parameter int TMR_W    = 6,
  parameter int STEP_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lim_big_pls,
  input  logic                    adc_big_pls,
  input  logic                    lim_small_pls,
  input  logic                    adc_small_pls,
  input  logic                    dsat_pls,
  input  logic                    pwr_low,
  input  logic                    pwr_high,
  input  logic [TMR_W-1:0]        upd_period,
  input  logic [CNT_W-1:0]        lim_limit,
  input  logic [CNT_W-1:0]        adc_limit,
  input  logic [CNT_W-1:0]        dsat_limit,
  input  logic                    lim_immed_en,
  input  logic                    adc_immed_en,
  input  logic                    inhibit_inc,
  input  logic [STEP_W-1:0]       lim_dec_step,
  input  logic [STEP_W-1:0]       adc_dec_step,
  input  logic [STEP_W-1:0]       dig_step,
  input  logic [STEP_W-1:0]       win_inc_step,
  input  logic [STEP_W-1:0]       win_dec_step,
  output logic [IDX_W-1:0]        gain_idx,
  output logic                    chg_valid,
  output logic signed [IDX_W:0]   chg_delta
);
  localparam int DW     = IDX_W + 1;
  localparam int N_SRC  = 3;   // 0 limiter, 1 ADC, 2 saturation

  // named internal events for the checker
  logic             expire_w;
  logic             fire_w;
  agc_src_e         src_w;
  logic             clr_w;
  logic             small_trip_w;
  logic             lim_q_w, adc_q_w, dsat_q_w;
  logic [CNT_W-1:0] lim_cnt_w, adc_cnt_w, dsat_cnt_w;
  logic signed [DW-1:0] req_delta_w;

  logic [N_SRC-1:0]            pls_v;
  logic [N_SRC-1:0]            qual_v;
  logic [N_SRC-1:0][CNT_W-1:0] lim_v;
  logic [N_SRC-1:0][CNT_W-1:0] cnt_v;

  assign pls_v = {dsat_pls, adc_big_pls, lim_big_pls};
  assign lim_v = {dsat_limit, adc_limit, lim_limit};
  assign clr_w = fire_w | expire_w;

  for (genvar g = 0; g < N_SRC; g++) begin : g_occ
    agc_occ_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_w),
      .pulse (pls_v[g]),
      .limit (lim_v[g]),
      .cnt   (cnt_v[g]),
      .qual  (qual_v[g])
    );
  end

  assign lim_q_w    = qual_v[0];
  assign adc_q_w    = qual_v[1];
  assign dsat_q_w   = qual_v[2];
  assign lim_cnt_w  = cnt_v[0];
  assign adc_cnt_w  = cnt_v[1];
  assign dsat_cnt_w = cnt_v[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              small_trip_w <= 1'b0;
    else if (clr_w)                          small_trip_w <= 1'b0;
    else if (lim_small_pls || adc_small_pls) small_trip_w <= 1'b1;
  end

  agc_update_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (upd_period),
    .expire (expire_w)
  );

  agc_decide #(.STEP_W(STEP_W), .DW(DW)) u_dec (
    .expire      (expire_w),
    .lim_q       (lim_q_w),
    .adc_q       (adc_q_w),
    .dsat_q      (dsat_q_w),
    .lim_imm_en  (lim_immed_en),
    .adc_imm_en  (adc_immed_en),
    .pwr_low     (pwr_low),
    .pwr_high    (pwr_high),
    .inhibit_inc (inhibit_inc),
    .small_trip  (small_trip_w),
    .lim_step    (lim_dec_step),
    .adc_step    (adc_dec_step),
    .dig_step    (dig_step),
    .inc_step    (win_inc_step),
    .dec_step    (win_dec_step),
    .fire        (fire_w),
    .src         (src_w),
    .req_delta   (req_delta_w)
  );

  agc_index_reg #(
    .IDX_W(IDX_W), .DW(DW), .MAX_IDX(MAX_IDX), .INIT_IDX(INIT_IDX)
  ) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire_w),
    .req_delta (req_delta_w),
    .gain_idx  (gain_idx),
    .chg_valid (chg_valid),
    .chg_delta (chg_delta)
  );
endmodule

// File: rtl/agc_peak_arbiter_chk.sv
`timescale 1ns/1ps
module agc_peak_arbiter_chk import agc_pkg::*; #(
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 3,
  parameter int MAX_IDX = 76
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  expire_w,
  input logic                  fire_w,
  input agc_src_e              src_w,
  input logic                  lim_q_w,
  input logic                  adc_q_w,
  input logic                  small_trip_w,
  input logic [CNT_W-1:0]      lim_cnt_w,
  input logic [CNT_W-1:0]      adc_cnt_w,
  input logic [CNT_W-1:0]      dsat_cnt_w,
  input logic                  lim_immed_en,
  input logic                  adc_immed_en,
  input logic                  inhibit_inc,
  input logic [IDX_W-1:0]      gain_idx,
  input logic                  chg_valid,
  input logic signed [IDX_W:0] chg_delta
);
  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gain_idx) <= MAX_IDX);

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_valid |-> gain_idx == $past(gain_idx));

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> int'(gain_idx) == int'($past(gain_idx)) + int'(chg_delta));

  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> chg_valid);

  // R3
  immed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !expire_w) |-> ((lim_immed_en && lim_q_w) || (adc_immed_en && adc_q_w)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w || expire_w) |=> (lim_cnt_w == '0 && adc_cnt_w == '0 &&
                              dsat_cnt_w == '0 && !small_trip_w));

  // R5
  lim_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && lim_q_w) |-> src_w == SRC_LIM);

  // R7
  no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_inc && small_trip_w) |-> src_w != SRC_WINC);
endmodule

bind agc_peak_arbiter agc_peak_arbiter_chk #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_IDX(MAX_IDX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .expire_w     (expire_w),
  .fire_w       (fire_w),
  .src_w        (src_w),
  .lim_q_w      (lim_q_w),
  .adc_q_w      (adc_q_w),
  .small_trip_w (small_trip_w),
  .lim_cnt_w    (lim_cnt_w),
  .adc_cnt_w    (adc_cnt_w),
  .dsat_cnt_w   (dsat_cnt_w),
  .lim_immed_en (lim_immed_en),
  .adc_immed_en (adc_immed_en),
  .inhibit_inc  (inhibit_inc),
  .gain_idx     (gain_idx),
  .chg_valid    (chg_valid),
  .chg_delta    (chg_delta)
);

// File: tb/agc_peak_arbiter_tb.sv
`timescale 1ns/1ps
module agc_peak_arbiter_tb;
  localparam int IDX_W = 7, MAX_IDX = 76, INIT_IDX = 40;
  localparam int CNT_W = 3, TMR_W = 6, STEP_W = 4;
  localparam int CNT_TOP = (1 << CNT_W) - 1;
  localparam int TMR_MOD = 1 << TMR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lim_big_pls = 0, adc_big_pls = 0, lim_small_pls = 0, adc_small_pls = 0, dsat_pls = 0;
  logic pwr_low = 0, pwr_high = 0;
  logic [TMR_W-1:0] upd_period = '0;
  logic [CNT_W-1:0] lim_limit = '0, adc_limit = '0, dsat_limit = '0;
  logic lim_immed_en = 0, adc_immed_en = 0, inhibit_inc = 0;
  logic [STEP_W-1:0] lim_dec_step = '0, adc_dec_step = '0, dig_step = '0;
  logic [STEP_W-1:0] win_inc_step = '0, win_dec_step = '0;
  logic [IDX_W-1:0] gain_idx;
  logic chg_valid;
  logic signed [IDX_W:0] chg_delta;

  always #5 clk = ~clk;

  agc_peak_arbiter #(
    .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .INIT_IDX(INIT_IDX),
    .CNT_W(CNT_W), .TMR_W(TMR_W), .STEP_W(STEP_W)
  ) u_dut (.*);

  int n_tests = 0, n_fail = 0;
  int m_tmr, m_cl, m_ca, m_cd, m_idx;
  bit m_sm;
  int d_lb, d_ab, d_ls, d_as, d_ds;   // pulse densities out of 16
  int pmode;                          // 0 quiet, 1 low, 2 high, 3 random
  logic [31:0] lfsr = 32'h1ACE_5EED;

  function automatic int rnd(input int n);
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr % 32'(n));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_tmr = 0; m_cl = 0; m_ca = 0; m_cd = 0; m_sm = 0; m_idx = INIT_IDX;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(gain_idx == IDX_W'(INIT_IDX), "R1 idx", int'(gain_idx), INIT_IDX);
    chk(chg_valid == 1'b0, "R1 valid", int'(chg_valid), 0);
    chk(chg_delta == '0, "R1 delta", int'(chg_delta), 0);
    rst_n = 1'b1;
  endtask

  // one clock: model from requirements, then compare the outputs
  task automatic tick(input string tag);
    bit ex, lq, aq, dq, now, f;
    int req, t, applied;
    string why;
    ex  = (m_tmr == int'(upd_period));                       // R3
    lq  = m_cl > int'(lim_limit);                            // R2
    aq  = m_ca > int'(adc_limit);
    dq  = m_cd > int'(dsat_limit);
    now = ex || (lim_immed_en && lq) || (adc_immed_en && aq); // R4
    f = 0; req = 0; why = "";
    if (now && lq)                       begin f = 1; req = -int'(lim_dec_step);     why = "R5 R6 lim"; end
    else if (now && aq)                  begin f = 1; req = -int'(adc_dec_step);     why = "R5 R6 adc"; end
    else if (ex && dq)                   begin f = 1; req = -(int'(dig_step) + 1);   why = "R6 dsat"; end
    else if (ex && pwr_high)             begin f = 1; req = -int'(win_dec_step);     why = "R6 wdec"; end
    else if (ex && pwr_low && !(inhibit_inc && m_sm))
                                         begin f = 1; req = int'(win_inc_step);      why = "R7 winc"; end
    t = m_idx + req;
    if (t < 0) t = 0;
    if (t > MAX_IDX) t = MAX_IDX;                            // R9
    applied = t - m_idx;
    if (f) m_idx = t;
    if (f || ex) begin                                       // R8
      m_cl = 0; m_ca = 0; m_cd = 0; m_sm = 0;
    end else begin
      if (lim_big_pls && m_cl < CNT_TOP) m_cl++;
      if (adc_big_pls && m_ca < CNT_TOP) m_ca++;
      if (dsat_pls    && m_cd < CNT_TOP) m_cd++;
      if (lim_small_pls || adc_small_pls) m_sm = 1;
    end
    m_tmr = ex ? 0 : (m_tmr + 1) % TMR_MOD;
    @(posedge clk);
    #2;
    chk(chg_valid == f, {tag, " valid ", why}, int'(chg_valid), int'(f));
    if (f) chk(int'(chg_delta) == applied, {tag, " delta ", why}, int'(chg_delta), applied);
    // R10 index follows the reported change
    chk(int'(gain_idx) == m_idx, {tag, " R10 idx"}, int'(gain_idx), m_idx);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      lim_big_pls   = rnd(16) < d_lb;
      adc_big_pls   = rnd(16) < d_ab;
      lim_small_pls = rnd(16) < d_ls;
      adc_small_pls = rnd(16) < d_as;
      dsat_pls      = rnd(16) < d_ds;
      case (pmode)
        1: begin pwr_low = 1; pwr_high = 0; end
        2: begin pwr_low = 0; pwr_high = 1; end
        3: begin pwr_low = rnd(2) == 1; pwr_high = rnd(3) == 0; end
        default: begin pwr_low = 0; pwr_high = 0; end
      endcase
      tick(tag);
    end
  endtask

  task automatic cfg(input int lb, ab, ls, as_, ds, pm);
    d_lb = lb; d_ab = ab; d_ls = ls; d_as = as_; d_ds = ds; pmode = pm;
  endtask

  initial begin
    #(150000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    lim_dec_step = 4'd3; adc_dec_step = 4'd2; dig_step = 4'd1;
    win_inc_step = 4'd2; win_dec_step = 4'd1;
    @(negedge clk);

    // R2: strict qualification, sweep limits with immediate action
    for (int lim = 0; lim < 5; lim++) begin
      upd_period = 6'd63; lim_immed_en = 1; adc_immed_en = 1;
      lim_limit = CNT_W'(lim); adc_limit = CNT_W'(lim + 1); dsat_limit = 3'd7;
      do_reset(); cfg(3, 3, 0, 0, 0, 0);
      run(100, "R2");
    end

    // R3: timer-gated decisions over several periods
    for (int p = 2; p < 8; p++) begin
      upd_period = TMR_W'(p); lim_immed_en = 0; adc_immed_en = 0;
      lim_limit = 3'd1; adc_limit = 3'd0; dsat_limit = 3'd1;
      do_reset(); cfg(2, 4, 0, 0, 3, 3);
      run(80, "R3");
    end

    // R4: ADC immediate only, limiter waits for timer
    upd_period = 6'd40; lim_immed_en = 0; adc_immed_en = 1;
    lim_limit = 3'd2; adc_limit = 3'd1;
    do_reset(); cfg(2, 6, 0, 0, 0, 0);
    run(150, "R4");

    // R5: everything at once
    upd_period = 6'd5; lim_immed_en = 0; adc_immed_en = 0;
    lim_limit = 3'd0; adc_limit = 3'd0; dsat_limit = 3'd0;
    do_reset(); cfg(10, 10, 4, 4, 10, 3);
    run(100, "R5");
    lim_immed_en = 1; adc_immed_en = 1;
    run(100, "R5");

    // R6: step size sweep per source
    for (int s = 0; s < 16; s++) begin
      lim_dec_step = STEP_W'(s); adc_dec_step = STEP_W'(15 - s);
      dig_step = STEP_W'(s); win_inc_step = STEP_W'(s); win_dec_step = STEP_W'(15 - s);
      upd_period = 6'd3; lim_immed_en = 0; adc_immed_en = 0;
      lim_limit = 3'd3; adc_limit = 3'd2; dsat_limit = 3'd0;
      do_reset(); cfg(4, 5, 0, 0, 8, 3);
      run(40, "R6");
    end

    // R7: small peaks with and without the increase block
    lim_dec_step = 4'd3; adc_dec_step = 4'd2; dig_step = 4'd1;
    win_inc_step = 4'd2; win_dec_step = 4'd1;
    upd_period = 6'd6; lim_limit = 3'd7; adc_limit = 3'd7; dsat_limit = 3'd7;
    inhibit_inc = 1;
    do_reset(); cfg(0, 0, 2, 2, 0, 1);
    run(200, "R7");
    inhibit_inc = 0;
    run(200, "R7");

    // R8: dense pulses against frequent clears
    upd_period = 6'd1; lim_limit = 3'd1; adc_limit = 3'd1; dsat_limit = 3'd1;
    lim_immed_en = 1; adc_immed_en = 0; inhibit_inc = 1;
    do_reset(); cfg(12, 12, 8, 8, 12, 3);
    run(300, "R8");

    // R9: drive index to zero, then to the table maximum
    upd_period = 6'd2; lim_limit = 3'd0; lim_immed_en = 1; lim_dec_step = 4'd15;
    inhibit_inc = 0;
    do_reset(); cfg(8, 0, 0, 0, 0, 0);
    run(100, "R9 low");
    win_inc_step = 4'd15; lim_immed_en = 0;
    cfg(0, 0, 0, 0, 0, 1);
    run(100, "R9 high");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule